// File: doc/BRIEF.md
# SMBus Host Notify Receiver

This block is the slave-side listener that a system host uses to take in notify messages from devices on a two-wire management bus. A device that wants attention takes the bus as master and writes a three-byte frame to the host's own slave address with the write bit. The first byte after the address is the device's own address in the upper seven bits, with bit 0 unused. The next two bytes are a 16-bit status word, low byte first. The receiver acknowledges the address byte and each of the three data bytes by pulling SDA low during the ninth clock.

On a valid stop that ends a complete frame, the receiver latches the sender's address and the status word into output registers and raises an interrupt. The values stay latched until software pulses the clear input. While a notification waits for service, a new notify frame gets no acknowledge at its address byte. The sender therefore sees a NACK and retries later, and the pending values are never overwritten.

Bus lines are brought in through a synchronizer, and start, stop and SCL edges are detected in the system clock domain. A controller with six states (IDLE, ADDR, ACK_WAIT, ACK_DRIVE, DATA, SKIP) sequences the frame. A stop sends every state to IDLE. A start or repeated start sends every state to ADDR. IDLE waits for a start. ADDR collects eight bits and goes to ACK_WAIT on a match, or to SKIP otherwise. ACK_WAIT waits for SCL to fall and then enters ACK_DRIVE, where SDA is held low. ACK_DRIVE releases SDA on the next SCL fall and enters DATA. DATA collects a byte and goes to ACK_WAIT for each of the first three bytes, or to SKIP on a fourth. SKIP ignores the bus until the next stop or start.

Top module: `smbus_notify_rx`

## Requirements
- R1: After reset, irq_o is low, sda_oe_o is low, and dev_addr_o and status_o are zero.
- R2: An address byte equal to {HOST_ADDR (default 7'h08), write bit 0}, sent MSB first, is acknowledged when no notification is pending: SDA reads low while SCL is high in the ninth clock.
- R3: An address byte with any other 7-bit address, or with the read bit 1, is not acknowledged and never raises irq_o.
- R4: The first three bytes after a matched address are each acknowledged, and a fourth byte is not acknowledged.
- R5: A stop directly after the third acknowledged byte raises irq_o, sets dev_addr_o to bits 7:1 of the first byte, and sets status_o to {third byte, second byte}.
- R6: A frame ended by a stop after zero, one or two data bytes leaves irq_o low.
- R7: A frame with four or more data bytes leaves irq_o low after its stop.
- R8: While irq_o is high, the address byte of a further notify frame is not acknowledged, and dev_addr_o and status_o keep their values.
- R9: A pulse on irq_clr_i drops irq_o on the following cycle. The latched values stay on the outputs, and the next valid frame is accepted again.
- R10: A repeated start restarts frame reception, so a partial frame followed by a repeated start and a full frame reports the full frame's values.
- R11: sda_oe_o changes only after a detected SCL falling edge and is never high while SCL is high during a data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) when high |
| irq_clr_i | input | 1 | Software acknowledge pulse; clears the interrupt |
| irq_o | output | 1 | Notification pending interrupt |
| dev_addr_o | output | 7 | Latched 7-bit address of the notifying device |
| status_o | output | 16 | Latched status word |

## Verification
A wrong bit count or shifter state shows up within the same byte, as an acknowledge in the wrong clock or a missing one. A bench master sampling SDA in the ninth clock of every byte catches it. A wrong byte index shows up at the stop that ends the frame: irq_o rises for a short or long frame, or the latched address or word holds the wrong bytes, visible a few cycles after the stop. A lost or stuck pending state shows up at the next frame's address byte as a wrong acknowledge, or as overwritten outputs.

// File: rtl/hn_pkg.sv
package hn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_DATA,
        ST_SKIP
    } hn_state_e;

    localparam int FRAME_BYTES = 3;
    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 7;
    localparam int WORD_W      = 2 * BYTE_W;

endpackage

// File: rtl/hn_bus_cond.sv
module hn_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_s;
    logic                   sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= SYNC_STAGES'({scl_pipe, scl_i});
            sda_pipe <= SYNC_STAGES'({sda_pipe, sda_i});
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_s      = scl_pipe[SYNC_STAGES-1];
    assign sda_s      = sda_pipe[SYNC_STAGES-1];
    assign sda_s_o    = sda_s;
    assign scl_rise_o = scl_s & ~scl_prev;
    assign scl_fall_o = ~scl_s & scl_prev;
    assign start_o    = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_o     = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/hn_shift.sv
module hn_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] data_o,
    output logic             full_o,
    output logic             one_o
);

    localparam int CW = $clog2(WIDTH + 2);

    logic [CW-1:0]    cnt_q;
    logic [WIDTH-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            data_q <= '0;
        end else if (clr_i) begin
            cnt_q  <= '0;
        end else if (shift_i) begin
            data_q <= {data_q[WIDTH-2:0], bit_i};
            if (cnt_q != CW'(WIDTH + 1)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign data_o = data_q;
    assign full_o = (cnt_q == CW'(WIDTH));
    assign one_o  = (cnt_q == CW'(1));

endmodule

// File: rtl/hn_notify_regs.sv
module hn_notify_regs
    import hn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en_i,
    input  logic [1:0]        cap_idx_i,
    input  logic [BYTE_W-1:0] cap_byte_i,
    input  logic              commit_i,
    input  logic              clr_i,
    output logic              pending_o,
    output logic [ADDR_W-1:0] dev_addr_o,
    output logic [WORD_W-1:0] status_o
);

    logic [ADDR_W-1:0] dev_shadow;
    logic [BYTE_W-1:0] word_shadow [FRAME_BYTES-1];
    logic              pending_q;
    logic [ADDR_W-1:0] dev_q;
    logic [WORD_W-1:0] status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_shadow <= '0;
        end else if (cap_en_i && cap_idx_i == 2'd0) begin
            dev_shadow <= cap_byte_i[BYTE_W-1:1];
        end
    end

    for (genvar g = 0; g < FRAME_BYTES - 1; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_shadow[g] <= '0;
            end else if (cap_en_i && cap_idx_i == 2'(g + 1)) begin
                word_shadow[g] <= cap_byte_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            dev_q     <= '0;
            status_q  <= '0;
        end else if (commit_i) begin
            pending_q <= 1'b1;
            dev_q     <= dev_shadow;
            status_q  <= {word_shadow[1], word_shadow[0]};
        end else if (clr_i) begin
            pending_q <= 1'b0;
        end
    end

    assign pending_o  = pending_q;
    assign dev_addr_o = dev_q;
    assign status_o   = status_q;

endmodule

// File: rtl/smbus_notify_rx.sv
module smbus_notify_rx
    import hn_pkg::*;
#(
    parameter logic [6:0] HOST_ADDR   = 7'h08,
    parameter int         SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic        irq_clr_i,
    output logic        irq_o,
    output logic [6:0]  dev_addr_o,
    output logic [15:0] status_o
);

    localparam logic [BYTE_W-1:0] MATCH_BYTE = {HOST_ADDR, 1'b0};

    hn_state_e         state_q, state_d;
    logic [1:0]        idx_q, idx_d;
    logic              oe_q;
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              sh_clr, sh_en, byte_full, one_bit;
    logic [BYTE_W-1:0] rx_byte;
    logic              cap_en, commit, pending;

    hn_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    assign sh_en  = scl_rise && (state_q == ST_ADDR || state_q == ST_DATA);
    assign sh_clr = start_det || (state_q == ST_ACK_DRIVE && scl_fall);

    hn_shift #(.WIDTH(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (sh_clr),
        .shift_i (sh_en),
        .bit_i   (sda_s),
        .data_o  (rx_byte),
        .full_o  (byte_full),
        .one_o   (one_bit)
    );

    hn_notify_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en_i   (cap_en),
        .cap_idx_i  (idx_q),
        .cap_byte_i (rx_byte),
        .commit_i   (commit),
        .clr_i      (irq_clr_i),
        .pending_o  (pending),
        .dev_addr_o (dev_addr_o),
        .status_o   (status_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        cap_en  = 1'b0;
        commit  = 1'b0;
        if (stop_det) begin
            state_d = ST_IDLE;
            commit  = (state_q == ST_DATA) && (idx_q == 2'(FRAME_BYTES)) && one_bit;
        end else if (start_det) begin
            state_d = ST_ADDR;
            idx_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (byte_full) begin
                        state_d = (rx_byte == MATCH_BYTE && !pending) ? ST_ACK_WAIT : ST_SKIP;
                    end
                end
                ST_ACK_WAIT: begin
                    if (scl_fall) state_d = ST_ACK_DRIVE;
                end
                ST_ACK_DRIVE: begin
                    if (scl_fall) state_d = ST_DATA;
                end
                ST_DATA: begin
                    if (byte_full) begin
                        if (idx_q < 2'(FRAME_BYTES)) begin
                            cap_en  = 1'b1;
                            idx_d   = idx_q + 1'b1;
                            state_d = ST_ACK_WAIT;
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end
                end
                ST_SKIP: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= (state_d == ST_ACK_DRIVE);
        end
    end

    assign sda_oe_o = oe_q;
    assign irq_o    = pending;

endmodule

// File: rtl/hn_checker.sv
module hn_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        irq_clr,
    input logic        sda_oe,
    input logic [6:0]  dev_addr,
    input logic [15:0] status,
    input logic        scl_fall,
    input logic        stop_det
);

    // R5: interrupt only rises right after a detected stop
    a_r5_irq_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(stop_det));

    // R8: latched values hold while pending and not cleared
    a_r8_hold_values: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> ($stable(dev_addr) && $stable(status)));

    // R8: no acknowledge is driven while a notification is pending
    a_r8_no_ack_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !sda_oe);

    // R9: clear drops the interrupt on the next cycle
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_clr) |=> !irq);

    // R11: acknowledge drive begins only after an SCL falling edge
    a_r11_oe_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

endmodule

bind smbus_notify_rx hn_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq_o),
    .irq_clr  (irq_clr_i),
    .sda_oe   (sda_oe_o),
    .dev_addr (dev_addr_o),
    .status   (status_o),
    .scl_fall (scl_fall),
    .stop_det (stop_det)
);

// File: tb/smbus_notify_rx_tb_top.sv
`timescale 1ns/1ps
module smbus_notify_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        irq_clr = 1'b0;
    logic        sda_oe;
    logic        irq;
    logic [6:0]  dev_addr;
    logic [15:0] status;
    logic        sda_bus;
    int          n_checks = 0;
    int          n_fails = 0;
    int          oe_violations = 0;
    logic        ack;

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    smbus_notify_rx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .irq_clr_i  (irq_clr),
        .irq_o      (irq),
        .dev_addr_o (dev_addr),
        .status_o   (status)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_cyc(10);
        scl = 1'b1;   wait_cyc(10);
        sda_m = 1'b0; wait_cyc(10);
        scl = 1'b0;   wait_cyc(5);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(5);
        scl = 1'b1;   wait_cyc(10);
        sda_m = 1'b1; wait_cyc(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_cyc(5);
            scl = 1'b1;   wait_cyc(5);
            if (sda_oe) oe_violations++;
            wait_cyc(5);
            scl = 1'b0;   wait_cyc(5);
        end
        sda_m = 1'b1; wait_cyc(5);
        scl = 1'b1;   wait_cyc(5);
        acked = ~sda_bus;
        wait_cyc(5);
        scl = 1'b0;   wait_cyc(5);
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1; wait_cyc(1);
        irq_clr = 1'b0; wait_cyc(2);
    endtask

    // full notify frame with acknowledge checks
    task automatic notify(input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
        bus_start();
        send_byte(8'h10, ack); chk("R2 address ack", 32'(ack), 32'd1);
        send_byte(b1, ack);    chk("R4 byte1 ack", 32'(ack), 32'd1);
        send_byte(b2, ack);    chk("R4 byte2 ack", 32'(ack), 32'd1);
        send_byte(b3, ack);    chk("R4 byte3 ack", 32'(ack), 32'd1);
        bus_stop();
        wait_cyc(5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        wait_cyc(5);
        // R1 reset state
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 oe", 32'(sda_oe), 32'd0);
        chk("R1 dev_addr", 32'(dev_addr), 32'd0);
        chk("R1 status", 32'(status), 32'd0);
        rst_n = 1'b1;
        wait_cyc(5);

        // R2 / R3: sweep every 7-bit address with the write bit, plus read bit at host address
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            chk((a == 8) ? "R2 match ack" : "R3 other address nack", 32'(ack), (a == 8) ? 32'd1 : 32'd0);
            bus_stop();
        end
        bus_start();
        send_byte(8'h11, ack);
        chk("R3 read bit nack", 32'(ack), 32'd0);
        bus_stop();
        wait_cyc(5);
        chk("R3 no irq after sweep", 32'(irq), 32'd0);

        // R5 / R9: sweep of data patterns
        for (int k = 0; k < 12; k++) begin
            logic [7:0] b1, b2, b3;
            b1 = 8'(k * 29 + 7);
            b2 = 8'(k * 53 + 1);
            b3 = 8'(255 - k * 19);
            notify(b1, b2, b3);
            chk("R5 irq raised", 32'(irq), 32'd1);
            chk("R5 device address", 32'(dev_addr), 32'(b1 >> 1));
            chk("R5 status word", 32'(status), {16'd0, b3, b2});
            clear_irq();
            chk("R9 irq cleared", 32'(irq), 32'd0);
            chk("R9 values kept", 32'(status), {16'd0, b3, b2});
        end

        // R6 short frames
        for (int n = 0; n < 3; n++) begin
            bus_start();
            send_byte(8'h10, ack);
            for (int j = 0; j < n; j++) send_byte(8'(8'h5A + j), ack);
            bus_stop();
            wait_cyc(5);
            chk("R6 short frame ignored", 32'(irq), 32'd0);
        end

        // R7 / R4 long frame
        bus_start();
        send_byte(8'h10, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        send_byte(8'h44, ack);
        send_byte(8'h55, ack);
        chk("R4 fourth byte nack", 32'(ack), 32'd0);
        bus_stop();
        wait_cyc(5);
        chk("R7 long frame ignored", 32'(irq), 32'd0);

        // R8 pending protection
        notify(8'h3C, 8'hA1, 8'hB2);
        chk("R8 first irq", 32'(irq), 32'd1);
        bus_start();
        send_byte(8'h10, ack);
        chk("R8 address nack while pending", 32'(ack), 32'd0);
        send_byte(8'h50, ack);
        send_byte(8'h61, ack);
        send_byte(8'h72, ack);
        bus_stop();
        wait_cyc(5);
        chk("R8 dev_addr kept", 32'(dev_addr), 32'h1E);
        chk("R8 status kept", 32'(status), 32'hB2A1);
        clear_irq();
        chk("R9 cleared", 32'(irq), 32'd0);
        notify(8'h50, 8'h61, 8'h72);
        chk("R9 next frame accepted", 32'(status), 32'h7261);
        chk("R9 next dev_addr", 32'(dev_addr), 32'h28);
        clear_irq();

        // R10 repeated start
        bus_start();
        send_byte(8'h10, ack);
        send_byte(8'h99, ack);
        send_byte(8'h88, ack);
        notify(8'h0F, 8'hC3, 8'h5E);
        chk("R10 irq", 32'(irq), 32'd1);
        chk("R10 dev_addr", 32'(dev_addr), 32'h07);
        chk("R10 status", 32'(status), 32'h5EC3);
        clear_irq();

        chk("R11 no drive during data bits", 32'(oe_violations), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule